// File: doc/BRIEF.md
# Serial Channel with Fractional Stop Length and Loop Modes

This block is one full-duplex asynchronous serial channel. A programmable prescaler divides the system clock into a sixteen-times-oversampling tick. The transmitter and receiver both run on that tick. The transmitter takes characters from a two-entry queue. The receiver places finished characters into a four-entry queue. Word length, parity and a stop period set in sixteenths of a bit are all programmable. Optional request/clear-to-send handshaking throttles both directions.

Software reaches the channel through a small byte-wide register port. Writing offset 0 queues a character for transmission, and reading offset 0 takes the oldest received character. Offset 1 writes the frame setup and reads back the status. Offsets 2, 3 and 4 hold the stop extension, the prescaler divisor and the interrupt mask. Writing offset 5 issues commands, and reading it returns the frame setup. Three interrupt sources are each gated by a mask bit onto a single request line.

Four routing modes are available. Normal mode is plain full duplex. Echo mode passes the pin through while still receiving. Local loopback feeds the transmitter straight into the receiver. Remote loopback passes the pin through and keeps received data away from software.

Top module: `uart_chan`

## Requirements
- R1: Frame setup bits [1:0] select the data length as code+5 bits (0→5 … 3→8). A frame is one low start bit followed by the data bits, least significant first. Transmitted bits above the length are dropped, and received characters are zero-extended.
- R2: Frame setup bits [3:2] select parity: 0 none, 1 even, 2 odd, 3 none. When enabled, one parity bit follows the data, so that the count of ones over data plus parity is even (even) or odd (odd).
- R3: The transmitted stop period is 16+min(S,16) sixteenths of a bit, where S is offset 2 bits [4:0]. The line stays high for that long before the next start bit.
- R4: The receive queue holds 4 characters and the transmit queue 2. A write to a full transmit queue is ignored, and reading offset 0 with the receive queue empty returns 0. Status bits are: [0] receive data present, [1] transmit queue not full, [2] transmitter idle and empty, [3] parity error, [4] framing error, [5] overrun, [6] receive queue full.
- R5: With frame setup bit [4] set, rts_n is high exactly while the receive queue is full, and no new transmit frame starts while cts_n is high. With bit [4] clear, rts_n is low and cts_n is ignored.
- R6: With divisor D at offset 3, one sixteenth-bit tick occurs every D+1 clocks, so one bit lasts 16·(D+1) clocks.
- R7: The receiver checks the start bit half a bit after the falling edge. A low pulse shorter than half a bit yields no character.
- R8: A wrong parity bit sets the parity error flag. A stop bit sampled low sets the framing error flag. A character finishing while the receive queue is full is dropped and sets the overrun flag. All three flags hold until a write to offset 5 with bit [0] set.
- R9: irq is the OR of (mask[0] and receive data present), (mask[1] and transmit queue not full) and (mask[2] and any error flag), where the mask sits at offset 4 bits [2:0].
- R10: Frame setup bits [6:5]=1 (echo): txd follows rxd after the input synchronizer, the transmitter never drives the pin, and received characters still reach the queue.
- R11: Bits [6:5]=2 (local loopback): txd stays high, and transmitted characters arrive in the receive queue.
- R12: Bits [6:5]=3 (remote loopback): txd follows rxd, and received characters are not placed in the receive queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops receive data at offset 0) |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset |
| rxd | input | 1 | Serial input pin |
| txd | output | 1 | Serial output pin |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench times the stop period between two all-zero characters at three extension values, including one above the clamp. A design that miscounted sixteenths or skipped the clamp would show a gap of the wrong length. A low pulse of five clocks is sent to the receiver: an edge-triggered receiver without the mid-bit check would log a phantom character. The receive queue is filled past capacity with flow control on. A wrong overrun policy would either lose the first four characters or fail to flag the fifth, and a wrong handshake would leave rts_n low. Each loop mode is checked at the pin and at the queue: a swapped routing either leaks transmitter frames onto txd or leaves the receive queue empty where a character is expected.

// File: rtl/uart_pkg.sv
package uart_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_ECHO   = 2'd1,
    MODE_LOCAL  = 2'd2,
    MODE_REMOTE = 2'd3
  } chan_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP
  } phase_e;

  // Parity bit that completes the chosen polarity over the data bits.
  function automatic logic par_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction
endpackage

// File: rtl/uart_prescale.sv
module uart_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q >= div);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
endmodule

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  always_comb begin
    full    = (cnt_q == CW'(DEPTH));
    empty   = (cnt_q == '0);
    do_push = push && !full;
    do_pop  = pop && !empty;
    wr_d    = wr_q;
    rd_d    = rd_q;
    if (do_push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    cnt_d   = cnt_q + CW'(do_push) - CW'(do_pop);
    dout    = mem_q[rd_q];
    count   = cnt_q;
  end

  always_ff @(posedge clk)
    if (do_push) mem_q[wr_q] <= din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
#(
  parameter int STOP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [STOP_W-1:0] stop_x,
  input  logic              go,
  input  logic [7:0]        din,
  output logic              take,
  output logic              busy,
  output logic              line
);
  phase_e     ph_q, ph_d;
  logic [5:0] cnt_q, cnt_d, last;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d, masked;
  logic       par_q, par_d;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    par_d  = par_q;
    take   = 1'b0;
    masked = din & (8'hFF >> (2'd3 - len));
    last   = (ph_q == PH_STOP) ?
             6'd15 + ((stop_x > STOP_W'(16)) ? 6'd16 : 6'(stop_x)) : 6'd15;
    if (ph_q == PH_IDLE) begin
      if (go) begin
        take  = 1'b1;
        sh_d  = masked;
        par_d = par_of(masked, par_odd);
        cnt_d = '0;
        ph_d  = PH_START;
      end
    end else if (tick) begin
      if (cnt_q == last) begin
        cnt_d = '0;
        unique case (ph_q)
          PH_START: begin ph_d = PH_DATA; bit_d = '0; end
          PH_DATA: begin
            sh_d = sh_q >> 1;
            if (bit_q == 3'd4 + 3'(len)) ph_d = par_en ? PH_PAR : PH_STOP;
            else bit_d = bit_q + 1'b1;
          end
          PH_PAR:  ph_d = PH_STOP;
          default: ph_d = PH_IDLE;
        endcase
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    busy = (ph_q != PH_IDLE);
    unique case (ph_q)
      PH_START: line = 1'b0;
      PH_DATA:  line = sh_q[0];
      PH_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      par_q <= par_d;
    end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_in,
  input  logic [1:0] len,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       valid,
  output logic [7:0] data,
  output logic       par_err,
  output logic       frm_err
);
  phase_e     ph_q, ph_d;
  logic [3:0] cnt_q, cnt_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic       pb_q, pb_d, arm_q, arm_d, start;

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    pb_d    = pb_q;
    valid   = 1'b0;
    par_err = 1'b0;
    frm_err = 1'b0;
    data    = sh_q >> (2'd3 - len);
    start   = (ph_q == PH_IDLE) && tick && !rx_in && arm_q;
    arm_d   = rx_in | (arm_q & (ph_q == PH_IDLE) & ~start);
    if (start) begin
      ph_d  = PH_START;
      cnt_d = '0;
    end else if (tick && ph_q != PH_IDLE) begin
      cnt_d = cnt_q + 1'b1;
      if (ph_q == PH_START && cnt_q == 4'd7) begin
        cnt_d = '0;
        bit_d = '0;
        ph_d  = rx_in ? PH_IDLE : PH_DATA;
      end else if (ph_q != PH_START && cnt_q == 4'd15) begin
        unique case (ph_q)
          PH_DATA: begin
            sh_d = {rx_in, sh_q[7:1]};
            if (bit_q == 3'd4 + 3'(len)) ph_d = par_en ? PH_PAR : PH_STOP;
            else bit_d = bit_q + 1'b1;
          end
          PH_PAR: begin pb_d = rx_in; ph_d = PH_STOP; end
          default: begin
            valid   = 1'b1;
            frm_err = !rx_in;
            par_err = par_en && (pb_q != par_of(data, par_odd));
            ph_d    = PH_IDLE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      pb_q  <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      pb_q  <= pb_d;
      arm_q <= arm_d;
    end
endmodule

// File: rtl/uart_chan.sv
module uart_chan
  import uart_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int RX_DEPTH = 4,
  parameter int TX_DEPTH = 2,
  parameter int STOP_W   = 5,
  localparam int RX_CW   = $clog2(RX_DEPTH + 1),
  localparam int TX_CW   = $clog2(TX_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rxd,
  output logic       txd,
  input  logic       cts_n,
  output logic       rts_n,
  output logic       irq
);
  logic [1:0]        rst_sync_q;
  logic              rst_i;
  logic [6:0]        frame_q, frame_d;
  logic [STOP_W-1:0] stop_q, stop_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [2:0]        mask_q, mask_d;
  logic              pe_q, pe_d, fe_q, fe_d, ov_q, ov_d, err_clr;
  logic              rx_s1_q, rx_s2_q, rx_in, tick;
  chan_mode_e        mode;
  logic              flow, par_en, par_odd, cts_ok;
  logic              tx_take, tx_busy, tx_line, tx_full, tx_empty, tx_push;
  logic [7:0]        tx_dout, rx_dout, rx_data;
  logic [TX_CW-1:0]  tx_count;
  logic [RX_CW-1:0]  rx_count;
  logic              rx_valid, rx_perr, rx_ferr, rx_push, rx_pop, rx_full, rx_empty;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  assign rst_i = rst_sync_q[1];

  always_comb begin
    mode    = chan_mode_e'(frame_q[6:5]);
    flow    = frame_q[4];
    par_en  = (frame_q[3:2] == 2'd1) || (frame_q[3:2] == 2'd2);
    par_odd = (frame_q[3:2] == 2'd2);
    cts_ok  = !(flow && cts_n);
    rx_in   = (mode == MODE_LOCAL) ? tx_line : rx_s2_q;
    tx_push = wr_en && (addr == 3'd0);
    rx_pop  = rd_en && (addr == 3'd0);
    rx_push = rx_valid && (mode != MODE_REMOTE);
    unique case (mode)
      MODE_NORMAL: txd = tx_line;
      MODE_LOCAL:  txd = 1'b1;
      default:     txd = rx_s2_q;
    endcase
    rts_n   = flow && rx_full;
    irq     = |(mask_q & {pe_q | fe_q | ov_q, ~tx_full, ~rx_empty});
  end

  // register writes and error flags, next state
  always_comb begin
    frame_d = frame_q;
    stop_d  = stop_q;
    div_d   = div_q;
    mask_d  = mask_q;
    if (wr_en) begin
      unique case (addr)
        3'd1:    frame_d = wdata[6:0];
        3'd2:    stop_d  = wdata[STOP_W-1:0];
        3'd3:    div_d   = wdata[DIV_W-1:0];
        3'd4:    mask_d  = wdata[2:0];
        default: ;
      endcase
    end
    err_clr = wr_en && (addr == 3'd5) && wdata[0];
    pe_d    = !err_clr && (pe_q || (rx_valid && rx_perr));
    fe_d    = !err_clr && (fe_q || (rx_valid && rx_ferr));
    ov_d    = !err_clr && (ov_q || (rx_push && rx_full));
  end

  always_ff @(posedge clk or negedge rst_i)
    if (!rst_i) begin
      frame_q <= 7'h03;
      stop_q  <= '0;
      div_q   <= '0;
      mask_q  <= '0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      ov_q    <= 1'b0;
      rx_s1_q <= 1'b1;
      rx_s2_q <= 1'b1;
    end else begin
      frame_q <= frame_d;
      stop_q  <= stop_d;
      div_q   <= div_d;
      mask_q  <= mask_d;
      pe_q    <= pe_d;
      fe_q    <= fe_d;
      ov_q    <= ov_d;
      rx_s1_q <= rxd;
      rx_s2_q <= rx_s1_q;
    end

  always_comb begin
    unique case (addr)
      3'd0:    rdata = rx_empty ? 8'h00 : rx_dout;
      3'd1:    rdata = {1'b0, rx_full, ov_q, fe_q, pe_q,
                        !tx_busy && tx_empty, !tx_full, !rx_empty};
      3'd2:    rdata = 8'(stop_q);
      3'd3:    rdata = 8'(div_q);
      3'd4:    rdata = {5'd0, mask_q};
      3'd5:    rdata = {1'b0, frame_q};
      default: rdata = 8'h00;
    endcase
  end

  uart_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_i), .div(div_q), .tick(tick));

  uart_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_i), .push(tx_push), .din(wdata), .pop(tx_take),
    .dout(tx_dout), .count(tx_count), .full(tx_full), .empty(tx_empty));

  uart_tx #(.STOP_W(STOP_W)) u_tx (
    .clk(clk), .rst_n(rst_i), .tick(tick), .len(frame_q[1:0]),
    .par_en(par_en), .par_odd(par_odd), .stop_x(stop_q),
    .go(!tx_empty && cts_ok), .din(tx_dout), .take(tx_take),
    .busy(tx_busy), .line(tx_line));

  uart_rx u_rx (
    .clk(clk), .rst_n(rst_i), .tick(tick), .rx_in(rx_in), .len(frame_q[1:0]),
    .par_en(par_en), .par_odd(par_odd), .valid(rx_valid), .data(rx_data),
    .par_err(rx_perr), .frm_err(rx_ferr));

  uart_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_i), .push(rx_push), .din(rx_data), .pop(rx_pop),
    .dout(rx_dout), .count(rx_count), .full(rx_full), .empty(rx_empty));
endmodule

// File: rtl/uart_chan_chk.sv
module uart_chan_chk #(
  parameter int RX_DEPTH = 4,
  parameter int TX_DEPTH = 2,
  localparam int RX_CW   = $clog2(RX_DEPTH + 1),
  localparam int TX_CW   = $clog2(TX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flow,
  input logic             cts_n,
  input logic             tx_busy,
  input logic [RX_CW-1:0] rx_count,
  input logic [TX_CW-1:0] tx_count,
  input logic             ovr,
  input logic             clr,
  input logic [1:0]       mode,
  input logic             txd
);
  a_r4_rx_depth: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= RX_CW'(RX_DEPTH));

  a_r4_tx_depth: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= TX_CW'(TX_DEPTH));

  a_r5_cts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flow && cts_n && !tx_busy) |=> !tx_busy);

  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr) |=> ovr);

  a_r11_local_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> txd);
endmodule

bind uart_chan uart_chan_chk #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flow(frame_q[4]), .cts_n(cts_n),
  .tx_busy(tx_busy), .rx_count(rx_count), .tx_count(tx_count),
  .ovr(ov_q), .clr(err_clr), .mode(frame_q[6:5]), .txd(txd));

// File: tb/uart_chan_tb.sv
module uart_chan_tb;
  logic       clk, rst_n, wr_en, rd_en, rxd, cts_n;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       txd, rts_n, irq;
  int         n_chk, n_bad, bitc;
  bit         done;

  uart_chan u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .cts_n(cts_n),
    .rts_n(rts_n), .irq(irq));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {len[1:0], par[1:0], written[7:0], expected[7:0], parity bit}
  localparam logic [20:0] VEC [6] = '{
    {2'd3, 2'd0, 8'hA5, 8'hA5, 1'b0},
    {2'd3, 2'd1, 8'h5A, 8'h5A, 1'b0},
    {2'd3, 2'd2, 8'h5A, 8'h5A, 1'b1},
    {2'd0, 2'd1, 8'hFF, 8'h1F, 1'b1},
    {2'd1, 2'd2, 8'hC3, 8'h03, 1'b1},
    {2'd2, 2'd1, 8'hFE, 8'h7E, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
    rd_en = (a == 3'd0);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic drain_rx();
    logic [7:0] s, d;
    for (int i = 0; i < 6; i++) begin
      reg_rd(3'd1, s);
      if (s[0]) reg_rd(3'd0, d);
    end
  endtask

  task automatic send_rx(input int nb, input bit pe, input bit pb,
                         input logic [7:0] d, input bit bad_stop);
    rxd = 1'b0;
    repeat (bitc) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      repeat (bitc) @(negedge clk);
    end
    if (pe) begin
      rxd = pb;
      repeat (bitc) @(negedge clk);
    end
    rxd = !bad_stop;
    repeat (bitc) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * bitc) @(negedge clk);
  endtask

  task automatic wait_fall(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (txd == 1'b0) begin ok = 1'b1; break; end
    end
  endtask

  task automatic cap_tx(input int nb, input bit pe, output logic [7:0] d,
                        output logic pb, output logic st, output bit ok);
    d = '0; pb = 1'b0; st = 1'b0;
    wait_fall(ok);
    if (ok) begin
      repeat (bitc / 2) @(negedge clk);
      if (txd !== 1'b0) ok = 1'b0;
      for (int i = 0; i < nb; i++) begin
        repeat (bitc) @(negedge clk);
        d[i] = txd;
      end
      if (pe) begin
        repeat (bitc) @(negedge clk);
        pb = txd;
      end
      repeat (bitc) @(negedge clk);
      st = txd;
    end
  endtask

  task automatic count_lows(input int cycles, output int lows);
    lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
  endtask

  task automatic stop_gap(input int e);
    bit ok;
    int n;
    int s;
    s = (e > 16) ? 16 : e;
    reg_wr(3'd2, 8'(e));
    reg_wr(3'd0, 8'h00);
    reg_wr(3'd0, 8'h00);
    wait_fall(ok);
    while (txd == 1'b0) @(negedge clk);
    n = 0;
    while (txd == 1'b1 && n < 200) begin n++; @(negedge clk); end
    check_rng("R3 stop gap", n, 16 + s, 18 + s);
    repeat (12 * bitc) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, s;
    logic       pb, st;
    bit         ok;
    int         lows;
    n_chk = 0; n_bad = 0; done = 1'b0; bitc = 16;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    rxd = 1'b1; cts_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    reg_rd(3'd1, s);
    check("R4 reset status", s, 8'h06);
    check("R9 reset irq", irq, 0);
    check("R5 reset rts_n", rts_n, 0);
    check("R10 reset txd idle", txd, 1);
    reg_rd(3'd0, d);
    check("R4 empty read", d, 0);

    // table of frame formats: transmit and receive
    for (int i = 0; i < 6; i++) begin
      logic [20:0] v;
      int nb;
      bit pe;
      v  = VEC[i];
      nb = 5 + int'(v[20:19]);
      pe = (v[18:17] == 2'd1) || (v[18:17] == 2'd2);
      reg_wr(3'd1, {3'b000, v[18:17], v[20:19]});
      reg_wr(3'd0, v[16:9]);
      cap_tx(nb, pe, d, pb, st, ok);
      check("R1 tx frame seen", ok, 1);
      check("R1 tx data", d, v[8:1]);
      if (pe) check("R2 tx parity", pb, v[0]);
      check("R3 tx stop high", st, 1);
      repeat (2 * bitc) @(negedge clk);
      send_rx(nb, pe, v[0], v[8:1], 1'b0);
      reg_rd(3'd1, s);
      check("R2 no parity error", s[3], 0);
      reg_rd(3'd0, d);
      check("R1 rx data", d, v[8:1]);
    end
    reg_wr(3'd1, 8'h03);

    // prescaler
    reg_wr(3'd3, 8'd1);
    bitc = 32;
    reg_wr(3'd0, 8'h01);
    wait_fall(ok);
    lows = 1;
    while (txd == 1'b0 && lows < 100) begin lows++; @(negedge clk); end
    lows--;
    check_rng("R6 start bit at div 1", lows, 31, 33);
    repeat (12 * bitc) @(negedge clk);
    reg_wr(3'd3, 8'd0);
    bitc = 16;
    reg_wr(3'd0, 8'h01);
    wait_fall(ok);
    lows = 1;
    while (txd == 1'b0 && lows < 100) begin lows++; @(negedge clk); end
    lows--;
    check_rng("R6 start bit at div 0", lows, 15, 17);
    repeat (12 * bitc) @(negedge clk);

    // fractional stop
    stop_gap(0);
    stop_gap(8);
    stop_gap(20);
    reg_wr(3'd2, 8'd0);

    // glitch rejection
    rxd = 1'b0;
    repeat (5) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * bitc) @(negedge clk);
    reg_rd(3'd1, s);
    check("R7 glitch ignored", s[0], 0);
    send_rx(8, 1'b0, 1'b0, 8'h3C, 1'b0);
    reg_rd(3'd0, d);
    check("R7 char after glitch", d, 8'h3C);

    // parity and framing errors, then clear
    reg_wr(3'd1, 8'h07);
    send_rx(8, 1'b1, 1'b1, 8'h11, 1'b0);
    reg_rd(3'd1, s);
    check("R8 parity error flag", s[3], 1);
    reg_wr(3'd4, 8'h04);
    check("R9 irq on error", irq, 1);
    reg_wr(3'd1, 8'h03);
    send_rx(8, 1'b0, 1'b0, 8'h22, 1'b1);
    reg_rd(3'd1, s);
    check("R8 framing error flag", s[4], 1);
    reg_wr(3'd5, 8'h01);
    reg_rd(3'd1, s);
    check("R8 errors cleared", s[5:3], 0);
    check("R9 irq after clear", irq, 0);
    reg_wr(3'd4, 8'h00);
    drain_rx();

    // fill the receive queue with flow control on, then overrun
    reg_wr(3'd1, 8'h13);
    for (int i = 0; i < 4; i++) send_rx(8, 1'b0, 1'b0, 8'(8'h40 + i), 1'b0);
    check("R5 rts_n high when full", rts_n, 1);
    reg_rd(3'd1, s);
    check("R4 queue full status", s[6], 1);
    check("R8 no overrun yet", s[5], 0);
    send_rx(8, 1'b0, 1'b0, 8'h99, 1'b0);
    reg_rd(3'd1, s);
    check("R8 overrun flag", s[5], 1);
    for (int i = 0; i < 4; i++) begin
      reg_rd(3'd0, d);
      check("R4 receive order", d, 8'h40 + i);
      if (i == 0) check("R5 rts_n low after read", rts_n, 0);
    end
    reg_rd(3'd1, s);
    check("R4 queue empty after four", s[0], 0);
    reg_wr(3'd5, 8'h01);

    // clear to send
    cts_n = 1'b1;
    reg_wr(3'd0, 8'h5C);
    count_lows(5 * bitc, lows);
    check("R5 held while cts_n high", lows, 0);
    cts_n = 1'b0;
    cap_tx(8, 1'b0, d, pb, st, ok);
    check("R5 sent after cts_n low", d, 8'h5C);
    repeat (2 * bitc) @(negedge clk);
    reg_wr(3'd1, 8'h03);
    cts_n = 1'b1;
    reg_wr(3'd0, 8'hE1);
    cap_tx(8, 1'b0, d, pb, st, ok);
    check("R5 cts_n ignored when off", d, 8'hE1);
    cts_n = 1'b0;
    repeat (2 * bitc) @(negedge clk);

    // transmit queue depth: third write while two wait is dropped
    cts_n = 1'b1;
    reg_wr(3'd1, 8'h13);
    reg_wr(3'd0, 8'hA1);
    reg_wr(3'd0, 8'hA2);
    reg_wr(3'd0, 8'hA3);
    reg_rd(3'd1, s);
    check("R4 tx queue full", s[1], 0);
    reg_wr(3'd4, 8'h02);
    check("R9 no tx irq when full", irq, 0);
    cts_n = 1'b0;
    cap_tx(8, 1'b0, d, pb, st, ok);
    check("R4 first queued", d, 8'hA1);
    check("R9 tx irq when room", irq, 1);
    cap_tx(8, 1'b0, d, pb, st, ok);
    check("R4 second queued", d, 8'hA2);
    wait_fall(ok);
    check("R4 third write dropped", ok, 0);
    reg_wr(3'd1, 8'h03);

    // receive interrupt
    reg_wr(3'd4, 8'h01);
    check("R9 no rx irq when empty", irq, 0);
    send_rx(8, 1'b0, 1'b0, 8'h77, 1'b0);
    check("R9 rx irq", irq, 1);
    reg_wr(3'd4, 8'h00);
    check("R9 rx irq masked", irq, 0);
    drain_rx();

    // echo
    reg_wr(3'd1, 8'h23);
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 echo low", txd, 0);
    rxd = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 echo high", txd, 1);
    reg_wr(3'd0, 8'h00);
    count_lows(12 * bitc, lows);
    check("R10 transmitter off pin", lows, 0);
    send_rx(8, 1'b0, 1'b0, 8'h42, 1'b0);
    reg_rd(3'd0, d);
    check("R10 echo still receives", d, 8'h42);

    // local loopback
    reg_wr(3'd1, 8'h43);
    reg_wr(3'd0, 8'h96);
    count_lows(13 * bitc, lows);
    check("R11 pin idle", lows, 0);
    reg_rd(3'd0, d);
    check("R11 looped char", d, 8'h96);

    // remote loopback
    reg_wr(3'd1, 8'h63);
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 pin follows low", txd, 0);
    rxd = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 pin follows high", txd, 1);
    send_rx(8, 1'b0, 1'b0, 8'h5A, 1'b0);
    reg_rd(3'd1, s);
    check("R12 nothing queued", s[0], 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule